// File: doc/BRIEF.md
# Write-Only Two-Wire Command Receiver with Burst Framing

This block sits on a two-wire (I2C) bus as a receive-only target and turns host writes into register commands for a bank of 40 converter channels. SCL and SDA are sampled with the system clock through two-flop synchronizers. START, repeated START and STOP are detected from the sampled lines. The block answers only to its own seven-bit address and acknowledges each accepted byte by pulling SDA low through an open-drain enable.

After the address byte, the host sends a pointer byte that names a channel, then two data bytes. Each completed pair of data bytes yields one command with three fields: a channel number, a two-bit register select and a 12-bit data word. If the host does not send STOP, it may keep sending pointer-plus-pair groups without resending the address. A pointer of 0xFF starts an auto-incrementing burst, in which each data pair goes to the next channel starting at 0. After channel 39 the block falls back to pointer-plus-pair framing. STOP ends every mode.

Top module: `i2c_burst_slave`

## Requirements
- R1: The target address is the seven bits 1,0,1,0,1 followed by `addr_pins[1]` and `addr_pins[0]`. An address byte that matches with the direction bit (bit 0) at 0 is acknowledged.
- R2: A non-matching address byte is not acknowledged, and no byte after it is acknowledged or produces a command until the next START.
- R3: An address byte that matches but has the direction bit at 1 (read) is not acknowledged and produces no command.
- R4: An acknowledge drives `sda_drive_low` high from the SCL falling edge after the eighth bit to the SCL falling edge after the ninth bit. It is low at every other time.
- R5: After the address, a pointer byte gives the channel in its bits 5..0. The following two data bytes form one command. The first data byte carries the register select in bits 7..6 and data bits 11..8 in bits 3..0. The second data byte carries data bits 7..0.
- R6: Without a STOP, each further pointer byte plus two data bytes produces another command for the newly named channel.
- R7: Pointer 0xFF starts burst mode. Successive data pairs go to channels 0, 1, 2 and so on, one channel per pair.
- R8: The burst pair for channel 39 is the last one. The next byte is again treated as a pointer.
- R9: STOP leaves any mode. Bytes clocked after a STOP and before a new START are not acknowledged, and a burst does not carry over into the next transfer.
- R10: A repeated START restarts address reception. A data pair cut short by a START or STOP produces no command.
- R11: After reset, `sda_drive_low` and `cmd_valid` are low.
- R12: `cmd_valid` is a one-cycle pulse, asserted at the SCL falling edge that ends the second data byte, with the command fields valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| addr_pins | input | 2 | Low two bits of the target address |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| cmd_valid | output | 1 | One-cycle strobe for a completed command |
| cmd_chan | output | 6 | Channel number of the command |
| cmd_reg | output | 2 | Register select of the command |
| cmd_data | output | 12 | 12-bit data word of the command |

## Verification
The hardest case to reach is the end of an auto-increment burst. The fallback to pointer framing is only visible after forty full data pairs sent within a single transfer, and only if the byte that follows is then taken as a channel number. The stimulus therefore streams all forty pairs after a 0xFF pointer with no STOP, then sends a pointer to channel 5 and one more pair, and expects that command on channel 5. A second stimulus stops a burst after two pairs and starts a new transfer, to show the burst state was cleared.

// File: rtl/i2c_burst_pkg.sv
`timescale 1ns/1ps
package i2c_burst_pkg;
    localparam int BYTE_W = 8;
    localparam int DATA_W = 12;
    localparam int CHAN_W = 6;
    localparam int REG_W  = 2;
    localparam int CNT_W  = 4;

    localparam logic [4:0]        ADDR_FIXED = 5'b10101;
    localparam logic [BYTE_W-1:0] BURST_PTR  = 8'hFF;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR,
        PH_DHI,
        PH_DLO,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [REG_W-1:0]  regsel;
        logic [DATA_W-1:0] data;
    } dac_cmd_t;

    // hi6 = {regsel[1:0], data[11:8]}
    function automatic dac_cmd_t build_cmd(input logic [CHAN_W-1:0] chan,
                                           input logic [5:0]        hi6,
                                           input logic [BYTE_W-1:0] lo);
        dac_cmd_t c;
        c.chan   = chan;
        c.regsel = hi6[5:4];
        c.data   = {hi6[3:0], lo};
        return c;
    endfunction

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [1:0]        pins);
        return (b[7:1] == {ADDR_FIXED, pins}) && !b[0];
    endfunction
endpackage

// File: rtl/i2c_burst_sync.sv
`timescale 1ns/1ps
module i2c_burst_sync #(
    parameter int          WIDTH  = 2,
    parameter int          STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= INIT;
                    else     stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= INIT;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/i2c_burst_cond.sv
`timescale 1ns/1ps
module i2c_burst_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s && !scl_d;
    assign scl_fall  = !scl_s && scl_d;
    assign start_det = scl_s && scl_d && sda_d && !sda_s;
    assign stop_det  = scl_s && scl_d && !sda_d && sda_s;
endmodule

// File: rtl/i2c_burst_ctrl.sv
`timescale 1ns/1ps
module i2c_burst_ctrl
    import i2c_burst_pkg::*;
#(
    parameter int LAST_CHAN = 39
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sda_s,
    input  logic      scl_rise,
    input  logic      scl_fall,
    input  logic      start_det,
    input  logic      stop_det,
    input  logic [1:0] addr_pins,
    output logic      ack_drive,
    output logic      cmd_v,
    output dac_cmd_t  cmd
);
    localparam logic [CHAN_W-1:0] LAST_C   = CHAN_W'(LAST_CHAN);
    localparam logic [CNT_W-1:0]  CNT_DEC  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0]  CNT_ACK  = CNT_W'(BYTE_W + 1);

    phase_e             phase;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [5:0]         hi_q;
    logic [CHAN_W-1:0]  chan_q;
    logic               burst_q;
    logic               ack_q;
    logic               cmd_v_q;
    dac_cmd_t           cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            hi_q    <= '0;
            chan_q  <= '0;
            burst_q <= 1'b0;
            ack_q   <= 1'b0;
            cmd_v_q <= 1'b0;
            cmd_q   <= '0;
        end else begin
            cmd_v_q <= 1'b0;
            if (start_det) begin
                phase   <= PH_ADDR;
                bit_cnt <= '0;
                ack_q   <= 1'b0;
                burst_q <= 1'b0;
            end else if (stop_det) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                ack_q   <= 1'b0;
                burst_q <= 1'b0;
            end else if (scl_rise && bit_cnt < CNT_DEC) begin
                shreg   <= {shreg[BYTE_W-2:0], sda_s};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == CNT_DEC) begin
                bit_cnt <= CNT_ACK;
                unique case (phase)
                    PH_ADDR: begin
                        if (addr_hit(shreg, addr_pins)) begin
                            ack_q <= 1'b1;
                            phase <= PH_PTR;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    PH_PTR: begin
                        ack_q <= 1'b1;
                        phase <= PH_DHI;
                        if (shreg == BURST_PTR) begin
                            burst_q <= 1'b1;
                            chan_q  <= '0;
                        end else begin
                            burst_q <= 1'b0;
                            chan_q  <= shreg[CHAN_W-1:0];
                        end
                    end
                    PH_DHI: begin
                        ack_q <= 1'b1;
                        hi_q  <= {shreg[7:6], shreg[3:0]};
                        phase <= PH_DLO;
                    end
                    PH_DLO: begin
                        ack_q   <= 1'b1;
                        cmd_q   <= build_cmd(chan_q, hi_q, shreg);
                        cmd_v_q <= 1'b1;
                        if (burst_q && chan_q != LAST_C) begin
                            chan_q <= chan_q + 1'b1;
                            phase  <= PH_DHI;
                        end else begin
                            burst_q <= 1'b0;
                            phase   <= PH_PTR;
                        end
                    end
                    default: ack_q <= 1'b0;
                endcase
            end else if (scl_fall && bit_cnt == CNT_ACK) begin
                ack_q   <= 1'b0;
                bit_cnt <= '0;
            end
        end
    end

    assign ack_drive = ack_q;
    assign cmd_v     = cmd_v_q;
    assign cmd       = cmd_q;
endmodule

// File: rtl/i2c_burst_slave.sv
`timescale 1ns/1ps
module i2c_burst_slave
    import i2c_burst_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LAST_CHAN   = 39
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_pins,
    output logic              sda_drive_low,
    output logic              cmd_valid,
    output logic [CHAN_W-1:0] cmd_chan,
    output logic [REG_W-1:0]  cmd_reg,
    output logic [DATA_W-1:0] cmd_data
);
    logic [1:0] bus_s;
    logic       scl_rise, scl_fall, start_det, stop_det;
    dac_cmd_t   cmd;

    i2c_burst_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (bus_s)
    );

    i2c_burst_cond u_cond (
        .clk       (clk),
        .rst       (rst),
        .scl_s     (bus_s[1]),
        .sda_s     (bus_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_burst_ctrl #(.LAST_CHAN(LAST_CHAN)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sda_s     (bus_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_pins (addr_pins),
        .ack_drive (sda_drive_low),
        .cmd_v     (cmd_valid),
        .cmd       (cmd)
    );

    assign cmd_chan = cmd.chan;
    assign cmd_reg  = cmd.regsel;
    assign cmd_data = cmd.data;
endmodule

// File: rtl/i2c_burst_checker.sv
`timescale 1ns/1ps
module i2c_burst_checker #(
    parameter int LAST_CHAN = 39
) (
    input logic       clk,
    input logic       rst,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_drive_low,
    input logic       cmd_valid,
    input logic       burst_q,
    input logic [5:0] chan_q
);
    // R4: the open-drain enable only moves on an SCL fall or a bus condition
    a_r4_ack_edge: assert property (@(posedge clk) disable iff (rst)
        (sda_drive_low != $past(sda_drive_low)) |-> $past(scl_fall || start_det || stop_det));

    // R9: STOP releases the line
    a_r9_stop_release: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_drive_low);

    // R12: single-cycle strobe
    a_r12_cmd_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R12: a command appears right after an SCL fall
    a_r12_cmd_on_fall: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(scl_fall));

    // R7: a burst begins at channel 0
    a_r7_burst_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(burst_q) |-> chan_q == 6'd0);

    // R8: a burst never walks past the last channel
    a_r8_burst_bound: assert property (@(posedge clk) disable iff (rst)
        burst_q |-> chan_q <= 6'(LAST_CHAN));
endmodule

bind i2c_burst_slave i2c_burst_checker #(.LAST_CHAN(LAST_CHAN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_fall      (scl_fall),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .sda_drive_low (sda_drive_low),
    .cmd_valid     (cmd_valid),
    .burst_q       (u_ctrl.burst_q),
    .chan_q        (u_ctrl.chan_q)
);

// File: tb/tb_i2c_burst_slave.sv
`timescale 1ns/1ps
module tb_i2c_burst_slave;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  pins = 2'b10;
    logic        sda_drive_low, cmd_valid;
    logic [5:0]  cmd_chan;
    logic [1:0]  cmd_reg;
    logic [11:0] cmd_data;
    wire         sda_bus = sda_m & ~sda_drive_low;

    int errors = 0;
    int checks = 0;
    logic [19:0] exp_q [$];

    always #2 clk = ~clk;

    i2c_burst_slave dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
        .addr_pins(pins), .sda_drive_low(sda_drive_low),
        .cmd_valid(cmd_valid), .cmd_chan(cmd_chan),
        .cmd_reg(cmd_reg), .cmd_data(cmd_data)
    );

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl = 1'b1; wq(2*Q);
            scl = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        @(negedge clk); ack = !sda_bus;
        wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic send_exp(input logic [7:0] b, input logic exp_ack, input string tag);
        logic a;
        send_byte(b, a);
        check(a == exp_ack, tag, a, exp_ack);
    endtask

    // driver: sends a data pair and queues the command the monitor must see
    task automatic send_pair(input logic [5:0] ch, input logic [1:0] rg, input logic [11:0] d,
                             input string tag);
        exp_q.push_back({ch, rg, d});
        send_exp({rg, 2'b00, d[11:8]}, 1'b1, tag);
        send_exp(d[7:0], 1'b1, tag);
    endtask

    // monitor: compare each strobe with the head of the queue
    always @(negedge clk) begin
        if (!rst && cmd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R3/R9/R10 unexpected command", {cmd_chan, cmd_reg, cmd_data}, 0);
            end else begin
                logic [19:0] e;
                e = exp_q.pop_front();
                check({cmd_chan, cmd_reg, cmd_data} == e, "R5/R6/R7/R12 command",
                      {cmd_chan, cmd_reg, cmd_data}, e);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] my_w, my_r, wrong;
        my_w  = {5'b10101, 2'b10, 1'b0};
        my_r  = {5'b10101, 2'b10, 1'b1};
        wrong = {5'b10101, 2'b01, 1'b0};
        wq(5);
        @(negedge clk);
        check(sda_drive_low == 1'b0, "R11 drive after reset", sda_drive_low, 0);
        check(cmd_valid == 1'b0, "R11 strobe after reset", cmd_valid, 0);
        rst = 1'b0;
        wq(5);

        // R1 R5: four-byte write
        bus_start();
        send_exp(my_w, 1'b1, "R1 address ack");
        send_exp(8'd3, 1'b1, "R5 pointer ack");
        send_pair(6'd3, 2'b11, 12'hABC, "R5 data ack");
        wq(4); @(negedge clk);
        check(sda_drive_low == 1'b0, "R4 release after ninth clock", sda_drive_low, 0);
        bus_stop();

        // R6: repeated pointer groups
        bus_start();
        send_exp(my_w, 1'b1, "R1 address ack");
        send_exp(8'd7, 1'b1, "R6 pointer ack");
        send_pair(6'd7, 2'b01, 12'h123, "R6 data");
        send_exp(8'd12, 1'b1, "R6 pointer ack");
        send_pair(6'd12, 2'b10, 12'h456, "R6 data");
        send_exp(8'd39, 1'b1, "R6 pointer ack");
        send_pair(6'd39, 2'b00, 12'hFFF, "R6 data");
        bus_stop();

        // R3: read direction refused
        bus_start();
        send_exp(my_r, 1'b0, "R3 read nack");
        send_exp(8'd1, 1'b0, "R3 follow nack");
        bus_stop();

        // R2: wrong address
        bus_start();
        send_exp(wrong, 1'b0, "R2 wrong address nack");
        send_exp(8'd2, 1'b0, "R2 skip nack");
        send_exp(8'h0F, 1'b0, "R2 skip nack");
        send_exp(8'h55, 1'b0, "R2 skip nack");
        bus_stop();

        // R7 R8: full burst then pointer mode
        bus_start();
        send_exp(my_w, 1'b1, "R1 address ack");
        send_exp(8'hFF, 1'b1, "R7 burst pointer ack");
        for (int i = 0; i < 40; i++)
            send_pair(6'(i), 2'(i % 4), 12'(i * 97 + 5), "R7 burst data");
        send_exp(8'd5, 1'b1, "R8 pointer after burst");
        send_pair(6'd5, 2'b10, 12'h5A5, "R8 pointer mode");
        bus_stop();

        // R9: stop ends a burst; bytes after stop ignored
        bus_start();
        send_exp(my_w, 1'b1, "R1 address ack");
        send_exp(8'hFF, 1'b1, "R9 burst pointer ack");
        send_pair(6'd0, 2'b01, 12'h010, "R9 burst data");
        send_pair(6'd1, 2'b01, 12'h011, "R9 burst data");
        bus_stop();
        send_exp(my_w, 1'b0, "R9 byte without start nack");
        send_exp(8'd9, 1'b0, "R9 byte without start nack");
        bus_stop();
        bus_start();
        send_exp(my_w, 1'b1, "R1 address ack");
        send_exp(8'd9, 1'b1, "R9 pointer after new start");
        send_pair(6'd9, 2'b11, 12'h999, "R9 no burst carry");
        bus_stop();

        // R10: repeated start drops a partial pair; stop mid-pair too
        bus_start();
        send_exp(my_w, 1'b1, "R1 address ack");
        send_exp(8'd4, 1'b1, "R10 pointer ack");
        send_exp(8'hC7, 1'b1, "R10 first data ack");
        bus_start();
        send_exp(my_w, 1'b1, "R10 address after repeated start");
        send_exp(8'd6, 1'b1, "R10 pointer ack");
        send_pair(6'd6, 2'b00, 12'h321, "R10 data");
        send_exp(8'd2, 1'b1, "R10 pointer ack");
        send_exp(8'h81, 1'b1, "R10 first data ack");
        bus_stop();

        wq(20);
        check(exp_q.size() == 0, "R5 all commands seen", exp_q.size(), 0);
        @(negedge clk);
        check(sda_drive_low == 1'b0, "R4 idle release", sda_drive_low, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule